// File: doc/BRIEF.md
# Frequent-Value Compressed Word Array

This block is the data array of a cache that stores 32-bit words either in full or, when a word equals one of 32 programmable frequent values, as a 5-bit index into a table of those values. Every word has a one-bit kind flag, a 5-bit low field and a 27-bit high field. For a word held as an index, the high field is neither written nor read, and the block raises a per-word gate output so the storage cells of that high field can be switched off. A read always returns the full 32-bit word one clock after the request, whichever way the word is held.

A word-addressed port carries reads and writes. On a write, the incoming word is compared with every table entry in the same cycle. A hit stores the lowest matching index, and a miss stores the word split across the low and high fields. A separate configuration port loads table entries one at a time, so each application can install its own value set. Any write to the table is immediately visible to words that were already stored as indices. Software must therefore clear the array before it changes the table under live data. A synchronous clear input empties the array. An output counter reports how many words are currently held as indices.

Each cycle is decoded into one operation, with priority in this order: clear first, then store, then idle. Table loads and reads proceed independently of that decode.

Top module: `fv_word_array`

## Requirements
- R1: After reset, rdata is 0, enc_count is 0 and every pg_off bit is 0. Every table entry is 0, so a later write of the word 0x00000000 is stored as index 0 and raises its gate bit.
- R2: A write whose data equals a table entry stores that entry's index. From the cycle after the write edge, pg_off[addr] is 1, and a read of the address returns the full value.
- R3: A write whose data equals no table entry stores the word whole, with bits 4:0 in the low field and bits 31:5 in the high field. A read returns it unchanged, and pg_off[addr] is 0.
- R4: A read sampled at a clock edge updates rdata at that edge, one cycle of latency for both word kinds. While rd_en is low, rdata holds its value.
- R5: When the write data matches several table entries, the lowest matching index is the one stored.
- R6: A table load at an edge replaces entry cfg_idx. Index-held words read through the table content present at the read edge.
- R7: Overwriting an index-held word with a non-matching value drops its pg_off bit from the cycle after the store edge.
- R8: clr empties the array: every flag becomes "full word", every field becomes 0, enc_count becomes 0, and all pg_off bits become 0. A write presented in the same cycle as clr is ignored.
- R9: enc_count equals the number of index-held words at all times. It rises or falls by one only on a write that changes a word's kind, and an overwrite of the same kind leaves it unchanged.
- R10: A read and a write to the same address in one cycle return the content from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous array clear |
| wr_en | input | 1 | Store wdata at addr |
| rd_en | input | 1 | Read addr into rdata |
| addr | input | 6 | Word address shared by read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cfg_we | input | 1 | Load one table entry |
| cfg_idx | input | 5 | Table entry to load |
| cfg_val | input | 32 | Value for that entry |
| pg_off | output | 64 | Per-word high-field gate, 1 = high field switched off |
| enc_count | output | 7 | Number of index-held words |

## Verification
Every result of this block is due exactly one clock edge after the stimulus. The rdata value, each pg_off bit and enc_count all come from registers that load at the edge that samples the request. The bench therefore applies each operation at a falling edge and compares all three outputs at the following falling edge. It computes the expected values from a model whose state it advances just before that edge, using the table contents as they stood before the edge. Random traffic biased toward table values is run alongside directed sequences for duplicate table entries, same-cycle read and write, clear with a write, and table reloads under live data.

// File: rtl/fv_pkg.sv
package fv_pkg;

    localparam int WORD_W    = 32;
    localparam int FV_ENTRIES = 32;
    localparam int CODE_W    = $clog2(FV_ENTRIES);
    localparam int HIGH_W    = WORD_W - CODE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_STORE = 2'd1,
        OP_CLEAR = 2'd2
    } arr_op_e;

endpackage

// File: rtl/fv_table.sv
module fv_table #(
    parameter int N  = 32,
    parameter int W  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [W-1:0]  cfg_val,
    input  logic [W-1:0]  probe,
    output logic          hit,
    output logic [IW-1:0] hit_idx,
    input  logic [IW-1:0] look_idx,
    output logic [W-1:0]  look_val
);

    logic [W-1:0] ent_q [N];
    logic [N-1:0] eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else if (cfg_we) begin
            ent_q[cfg_idx] <= cfg_val;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign eq[g] = (ent_q[g] == probe);
        end
    endgenerate

    // Lowest matching index wins: scan from the top down.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign look_val = ent_q[look_idx];

    AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ent_q[$past(cfg_idx)] == $past(cfg_val)); // R6

    AST_HIT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_idx != '0) |-> !eq[hit_idx - 1'b1]); // R5

endmodule

// File: rtl/fv_store.sv
module fv_store #(
    parameter int DEPTH = 64,
    parameter int IW    = 5,
    parameter int HW    = 27,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_clear,
    input  logic             do_store,
    input  logic [AW-1:0]    addr,
    input  logic             enc,
    input  logic [IW-1:0]    code,
    input  logic [IW-1:0]    raw_lo,
    input  logic [HW-1:0]    raw_hi,
    output logic             rd_full,
    output logic [IW-1:0]    rd_lo,
    output logic [HW-1:0]    rd_hi,
    output logic             gain,
    output logic             loss,
    output logic [DEPTH-1:0] pg_off
);

    logic [DEPTH-1:0] full_q;
    logic [IW-1:0]    lo_q [DEPTH];
    logic [HW-1:0]    hi_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= '1;
            for (int i = 0; i < DEPTH; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (do_clear) begin
            full_q <= '1;
            for (int i = 0; i < DEPTH; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (do_store) begin
            full_q[addr] <= ~enc;
            lo_q[addr]   <= enc ? code : raw_lo;
            if (!enc) hi_q[addr] <= raw_hi;
        end
    end

    assign rd_full = full_q[addr];
    assign rd_lo   = lo_q[addr];
    assign rd_hi   = hi_q[addr];

    // Kind changes reported to the occupancy counter.
    assign gain = do_store &&  enc &&  full_q[addr];
    assign loss = do_store && !enc && !full_q[addr];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_gate
            assign pg_off[g] = ~full_q[g];
        end
    endgenerate

    AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (do_store && !do_clear && enc) |=> hi_q[$past(addr)] == $past(hi_q[addr])); // R2

    AST_FULL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (do_store && !do_clear && !enc) |=> {hi_q[$past(addr)], lo_q[$past(addr)]} == $past({raw_hi, raw_lo})); // R3

endmodule

// File: rtl/fv_count.sv
module fv_count #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_clear,
    input  logic          gain,
    input  logic          loss,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count <= '0;
        else if (do_clear) count <= '0;
        else if (gain)     count <= count + 1'b1;
        else if (loss)     count <= count - 1'b1;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gain && loss)); // R9

endmodule

// File: rtl/fv_word_array.sv
module fv_word_array
    import fv_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_idx,
    input  logic [WORD_W-1:0] cfg_val,
    output logic [DEPTH-1:0]  pg_off,
    output logic [CW-1:0]     enc_count
);

    arr_op_e           op;
    logic              do_clear;
    logic              do_store;
    logic              hit;
    logic [CODE_W-1:0] hit_idx;
    logic [WORD_W-1:0] look_val;
    logic              rd_full;
    logic [CODE_W-1:0] rd_lo;
    logic [HIGH_W-1:0] rd_hi;
    logic              gain;
    logic              loss;

    // Operation decode: clear outranks store.
    always_comb begin
        unique casez ({clr, wr_en})
            2'b1?:   op = OP_CLEAR;
            2'b01:   op = OP_STORE;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        do_clear = 1'b0;
        do_store = 1'b0;
        unique case (op)
            OP_CLEAR: do_clear = 1'b1;
            OP_STORE: do_store = 1'b1;
            default:  ;
        endcase
    end

    fv_table #(.N(FV_ENTRIES), .W(WORD_W), .IW(CODE_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_val  (cfg_val),
        .probe    (wdata),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .look_idx (rd_lo),
        .look_val (look_val)
    );

    fv_store #(.DEPTH(DEPTH), .IW(CODE_W), .HW(HIGH_W), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_clear (do_clear),
        .do_store (do_store),
        .addr     (addr),
        .enc      (hit),
        .code     (hit_idx),
        .raw_lo   (wdata[CODE_W-1:0]),
        .raw_hi   (wdata[WORD_W-1:CODE_W]),
        .rd_full  (rd_full),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .gain     (gain),
        .loss     (loss),
        .pg_off   (pg_off)
    );

    fv_count #(.DEPTH(DEPTH), .CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_clear (do_clear),
        .gain     (gain),
        .loss     (loss),
        .count    (enc_count)
    );

    // Single-cycle read for both kinds: select decoded or raw word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_full ? {rd_hi, rd_lo} : look_val;
    end

    AST_FV_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && hit) |=> pg_off[$past(addr)]); // R2

    AST_NFV_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && !hit) |=> !pg_off[$past(addr)]); // R7

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pg_off == '0 && enc_count == '0)); // R8

    AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(enc_count) == $countones(pg_off)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R4

endmodule

// File: tb/sim_fv_word_array.sv
`timescale 1ns/1ps
module sim_fv_word_array;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr, wr_en, rd_en, cfg_we;
    logic [5:0]  addr;
    logic [31:0] wdata, cfg_val;
    logic [4:0]  cfg_idx;
    logic [31:0] rdata;
    logic [63:0] pg_off;
    logic [6:0]  enc_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit          m_full [64];
    logic [4:0]  m_lo   [64];
    logic [26:0] m_hi   [64];
    logic [31:0] m_tbl  [32];
    logic [31:0] exp_rd;

    always #2.5 clk = ~clk;

    fv_word_array u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_val(cfg_val), .pg_off(pg_off), .enc_count(enc_count)
    );

    function automatic logic [31:0] ref_read(int a);
        return m_full[a] ? {m_hi[a], m_lo[a]} : m_tbl[m_lo[a]];
    endfunction

    function automatic logic [63:0] ref_gates();
        logic [63:0] v;
        for (int i = 0; i < 64; i++) v[i] = ~m_full[i];
        return v;
    endfunction

    function automatic int ref_count();
        int n = 0;
        for (int i = 0; i < 64; i++) if (!m_full[i]) n++;
        return n;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        clr = 0; wr_en = 0; rd_en = 0; cfg_we = 0;
        addr = '0; wdata = '0; cfg_idx = '0; cfg_val = '0;
    endtask

    // Called at a falling edge; results compared at the next falling edge.
    task automatic do_cycle(bit c, bit we, bit re, int a, logic [31:0] wd,
                            bit cwe, int ci, logic [31:0] cv, string tag);
        bit hit;
        int idx;
        clr = c; wr_en = we; rd_en = re; addr = a[5:0]; wdata = wd;
        cfg_we = cwe; cfg_idx = ci[4:0]; cfg_val = cv;
        if (re) exp_rd = ref_read(a);
        if (c) begin
            for (int i = 0; i < 64; i++) begin m_full[i] = 1; m_lo[i] = '0; m_hi[i] = '0; end
        end else if (we) begin
            hit = 0; idx = 0;
            for (int i = 31; i >= 0; i--) if (m_tbl[i] == wd) begin hit = 1; idx = i; end
            if (hit) begin m_full[a] = 0; m_lo[a] = idx[4:0]; end
            else begin m_full[a] = 1; m_lo[a] = wd[4:0]; m_hi[a] = wd[31:5]; end
        end
        if (cwe) m_tbl[ci] = cv;
        @(negedge clk);
        chk(tag, "rdata", {32'd0, rdata}, {32'd0, exp_rd});
        chk(tag, "pg_off", pg_off, ref_gates());
        chk(tag, "enc_count", {57'd0, enc_count}, 64'(ref_count()));
        idle_inputs();
    endtask

    task automatic rd(int a, string tag);
        do_cycle(0, 0, 1, a, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        do_cycle(0, 1, 0, a, d, 0, 0, 0, tag);
    endtask

    task automatic ld(int i, logic [31:0] v, string tag);
        do_cycle(0, 0, 0, 0, 0, 1, i, v, tag);
    endtask

    initial begin
        int unsigned r;
        idle_inputs();
        rst_n = 0;
        exp_rd = '0;
        for (int i = 0; i < 64; i++) begin m_full[i] = 1; m_lo[i] = '0; m_hi[i] = '0; end
        for (int i = 0; i < 32; i++) m_tbl[i] = '0;
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset values
        chk("R1", "rdata", {32'd0, rdata}, 64'd0);
        chk("R1", "pg_off", pg_off, 64'd0);
        chk("R1", "enc_count", {57'd0, enc_count}, 64'd0);
        // R1: zero table encodes zero as index 0
        wr(5, 32'h0, "R1");
        rd(5, "R1");

        // R2: frequent value stored as index
        for (int i = 0; i < 32; i++) ld(i, 32'hA000_0000 + 32'(i * 17), "R6");
        wr(10, 32'hA000_0000 + 32'(7 * 17), "R2");
        rd(10, "R2");

        // R3: non-frequent word stored whole
        wr(11, 32'h1234_5678, "R3");
        rd(11, "R3");

        // R5 / R6: duplicate entries, then reload the lower one
        ld(3, 32'hCAFE_F00D, "R6");
        ld(9, 32'hCAFE_F00D, "R6");
        wr(12, 32'hCAFE_F00D, "R5");
        ld(3, 32'h0BAD_BEEF, "R5");
        rd(12, "R5");
        ld(3, 32'hA000_0000 + 32'(3 * 17), "R6");
        rd(12, "R6");

        // R7 / R9: overwrite encoded word with raw value
        wr(10, 32'h7777_0001, "R7");
        wr(11, 32'h5555_AAAA, "R9");
        wr(13, 32'hA000_0000 + 32'(2 * 17), "R9");
        wr(13, 32'hA000_0000 + 32'(4 * 17), "R9");

        // R10: read and write same address in one cycle
        do_cycle(0, 1, 1, 13, 32'h0F0F_0F0F, 0, 0, 0, "R10");
        rd(13, "R10");

        // R4: rdata holds with rd_en low
        wr(20, 32'h2222_3333, "R4");
        do_cycle(0, 0, 0, 20, 0, 0, 0, 0, "R4");

        // R8: clear with a simultaneous write
        do_cycle(1, 1, 0, 10, 32'hA000_0000, 0, 0, 0, "R8");
        rd(10, "R8");
        rd(13, "R8");

        // Random traffic, biased toward table values
        for (int n = 0; n < 4000; n++) begin
            bit c, we, re, cwe;
            int a, ci;
            logic [31:0] wd, cv;
            c   = ($urandom % 200) == 0;
            we  = ($urandom % 2) == 0;
            re  = ($urandom % 2) == 0;
            cwe = ($urandom % 25) == 0;
            a   = int'($urandom % 64);
            ci  = int'($urandom % 32);
            wd  = (($urandom % 3) != 0) ? m_tbl[$urandom % 32] : $urandom;
            cv  = (($urandom % 4) == 0) ? m_tbl[$urandom % 32] : $urandom;
            do_cycle(c, we, re, a, wd, cwe, ci, cv, "R4");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule